// File: doc/BRIEF.md
# Iterative Integer Divider with Condition Flags

This block divides integers over many clock cycles and returns the quotient, the remainder and four condition flags (N, Z, V, C). It has four modes. Two are word forms: a 32-bit dividend divided by a 16-bit divisor, unsigned or signed. Two are long forms: a 64-bit dividend divided by a 32-bit divisor, unsigned or signed. In the long forms the upper 32 bits of the dividend come from the remainder-register operand and the lower 32 bits come from the quotient-register operand. The surrounding execution unit reads both register operands, pulses `start`, and waits for `done`. It then writes the results back using the per-destination write enables, or raises a divide-by-zero exception when `div_zero` is reported.

The core divides magnitudes with a restoring shift-subtract loop that produces one quotient bit per clock. A sign correction is applied afterwards, so signed division truncates toward zero and the remainder takes the sign of the dividend. If the quotient does not fit the destination width, both writes are suppressed and the flags report the overflow. When the quotient and remainder destinations are the same register, only the quotient is written.

Top module: `idiv_flags_unit`

## Requirements
- R1: A `start` that is high while `busy` is low is accepted at that clock edge, and `busy` is high from the next cycle. A `start` that arrives while `busy` is high is ignored. `done` is a one-cycle pulse, `busy` is low in that same cycle, and `quo_we`, `rem_we` and `div_zero` are high only together with `done`. After reset, `busy`, `done`, both write enables and `div_zero` are low.
- R2: Latency is measured from the edge that accepts `start` to the edge after which `done` is high. It is 33 edges for the word forms, 65 edges for the long forms, and 1 edge when the divisor is zero.
- R3: A zero divisor produces `div_zero=1` with `done`, and both write enables stay low. The flags become N = `n_prev`, Z = 0, V = 0, C = 0. In the word forms only `divisor[15:0]` is tested for zero; in the long forms all 32 bits are tested.
- R4: `mode` is encoded as follows. Bit 0 set selects signed operation. Bit 1 set selects the long 64/32 form; clear selects the word 32/16 form. The word forms use `quo_src` as the dividend and `divisor[15:0]` as the divisor. The long forms use {`rem_src`,`quo_src`} as the dividend and the full `divisor`.
- R5: A word form without overflow sets `quo_res` = {remainder[15:0], quotient[15:0]}, `quo_we`=1 and `rem_we`=0.
- R6: Signed division truncates the quotient toward zero, and a non-zero remainder has the sign of the dividend.
- R7: A word form overflows when the quotient exceeds 0xFFFF (unsigned), or lies outside -32768..32767 (signed).
- R8: A long form overflows when the quotient exceeds 0xFFFFFFFF (unsigned), or lies outside the signed 32-bit range (signed).
- R9: On overflow, V=1, Z=0, N = `n_prev` and C=0, and both write enables stay low.
- R10: Without overflow or trap, V=0 and C=0. N is the sign bit of the quotient and Z is set when the quotient is zero, both taken at the destination width (16 bits for the word forms, 32 bits for the long forms).
- R11: A long form without overflow sets `quo_res` = quotient with `quo_we`=1. It sets `rem_res` = remainder with `rem_we`=1, unless `same_dst` is high; in that case `rem_we`=0 and the register receives only the quotient.
- R12: All operands, `mode`, `same_dst` and `n_prev` are captured at the accepting edge. Changing them while `busy` is high does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request a division |
| mode | input | 2 | Bit 0 signed, bit 1 long form |
| quo_src | input | W | Quotient-register operand (dividend, or its low half) |
| rem_src | input | W | Remainder-register operand (dividend high half, long forms) |
| divisor | input | W | Divisor (low half only in word forms) |
| same_dst | input | 1 | Quotient and remainder destinations are the same register |
| n_prev | input | 1 | Current N flag, kept on overflow or trap |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quo_res | output | W | Quotient, or packed remainder/quotient in word forms |
| rem_res | output | W | Remainder (long forms) |
| quo_we | output | 1 | Write the quotient destination |
| rem_we | output | 1 | Write the remainder destination |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag (always cleared) |
| div_zero | output | 1 | Divide-by-zero trap |

## Verification
Two events can fall in the same cycle: a result is presented with `done`, and the next `start` is accepted, because `busy` is already low in the completion cycle. The bench provokes this on about half of its operations by driving the next request in the cycle where it observes `done`. For each such operation it checks the finished result and also the chained operation's own result and latency. The bench also raises `start` in the middle of running divisions and scrambles the operands after acceptance. It judges that neither changes the result and that no extra `done` appears.

// File: rtl/idiv_pkg.sv
package idiv_pkg;
  localparam int MODE_SIGN_BIT = 0;
  localparam int MODE_LONG_BIT = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } dstate_e;
endpackage

// File: rtl/idiv_operand_prep.sv
module idiv_operand_prep
  import idiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]     mode_i,
  input  logic [W-1:0]   lo_i,
  input  logic [W-1:0]   hi_i,
  input  logic [W-1:0]   dvs_i,
  output logic [2*W-1:0] dvd_mag_o,
  output logic [W-1:0]   dvs_mag_o,
  output logic           dvd_neg_o,
  output logic           dvs_neg_o,
  output logic           dvs_zero_o
);
  localparam int HW = W / 2;
  localparam int DW = 2 * W;

  logic          sgn, lng;
  logic [DW-1:0] dvd_full;
  logic [W-1:0]  dvs_ext;

  always_comb begin
    sgn = mode_i[MODE_SIGN_BIT];
    lng = mode_i[MODE_LONG_BIT];
    // word forms use the low half of the divisor, extended per signedness
    if (lng)      dvs_ext = dvs_i;
    else if (sgn) dvs_ext = {{HW{dvs_i[HW-1]}}, dvs_i[HW-1:0]};
    else          dvs_ext = {{HW{1'b0}}, dvs_i[HW-1:0]};
    // long forms concatenate high and low register operands
    if (lng)      dvd_full = {hi_i, lo_i};
    else if (sgn) dvd_full = {{W{lo_i[W-1]}}, lo_i};
    else          dvd_full = {{W{1'b0}}, lo_i};
    dvd_neg_o  = sgn & dvd_full[DW-1];
    dvs_neg_o  = sgn & dvs_ext[W-1];
    dvd_mag_o  = dvd_neg_o ? -dvd_full : dvd_full;
    dvs_mag_o  = dvs_neg_o ? -dvs_ext : dvs_ext;
    dvs_zero_o = (dvs_ext == '0);
  end
endmodule

// File: rtl/idiv_restoring_core.sv
module idiv_restoring_core #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           long_i,
  input  logic [2*W-1:0] dvd_i,
  input  logic [W-1:0]   dvs_i,
  output logic [2*W-1:0] q_o,
  output logic [W-1:0]   r_o,
  output logic           last_o
);
  localparam int DW = 2 * W;
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] dq_q, dq_d;
  logic [W-1:0]  acc_q, acc_d;
  logic [W-1:0]  dvs_q, dvs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          step_en;
  logic [W:0]    trial;
  logic [W-1:0]  diff;
  logic          fits;

  always_comb begin
    trial   = {acc_q, dq_q[DW-1]};
    fits    = (trial >= {1'b0, dvs_q});
    diff    = trial[W-1:0] - dvs_q;
    step_en = load_i | (cnt_q != '0);
    dq_d    = dq_q;
    acc_d   = acc_q;
    dvs_d   = dvs_q;
    cnt_d   = cnt_q;
    if (load_i) begin
      // word forms place the 32-bit dividend in the upper half: W steps
      dq_d  = long_i ? dvd_i : {dvd_i[W-1:0], {W{1'b0}}};
      acc_d = '0;
      dvs_d = dvs_i;
      cnt_d = long_i ? CW'(DW) : CW'(W);
    end else if (cnt_q != '0) begin
      acc_d = fits ? diff : trial[W-1:0];
      dq_d  = {dq_q[DW-2:0], fits};
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_q  <= '0;
      acc_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (step_en) begin
      dq_q  <= dq_d;
      acc_q <= acc_d;
      dvs_q <= dvs_d;
      cnt_q <= cnt_d;
    end
  end

  assign q_o    = dq_q;
  assign r_o    = acc_q;
  assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/idiv_result_pack.sv
module idiv_result_pack #(
  parameter int W = 32
) (
  input  logic           long_i,
  input  logic           sgn_i,
  input  logic           q_neg_i,
  input  logic           r_neg_i,
  input  logic [2*W-1:0] q_mag_i,
  input  logic [W-1:0]   r_mag_i,
  input  logic           same_i,
  input  logic           n_prev_i,
  output logic [W-1:0]   quo_o,
  output logic [W-1:0]   rem_o,
  output logic           quo_we_o,
  output logic           rem_we_o,
  output logic           n_o,
  output logic           z_o,
  output logic           v_o
);
  localparam int HW = W / 2;
  localparam int DW = 2 * W;
  localparam logic [DW-1:0] LIM_WU  = {{(DW-HW){1'b0}}, {HW{1'b1}}};
  localparam logic [DW-1:0] LIM_WSP = {{(DW-HW+1){1'b0}}, {(HW-1){1'b1}}};
  localparam logic [DW-1:0] LIM_LU  = {{W{1'b0}}, {W{1'b1}}};
  localparam logic [DW-1:0] LIM_LSP = {{(W+1){1'b0}}, {(W-1){1'b1}}};

  logic [DW-1:0] lim;
  logic          ovf;
  logic [W-1:0]  q_val, r_val;

  always_comb begin
    // a negative quotient may reach one further than a positive one
    if (long_i) lim = sgn_i ? (LIM_LSP + DW'(q_neg_i)) : LIM_LU;
    else        lim = sgn_i ? (LIM_WSP + DW'(q_neg_i)) : LIM_WU;
    ovf   = (q_mag_i > lim);
    q_val = q_neg_i ? -q_mag_i[W-1:0] : q_mag_i[W-1:0];
    r_val = r_neg_i ? -r_mag_i : r_mag_i;
    rem_o = r_val;
    if (long_i) begin
      quo_o    = q_val;
      n_o      = q_val[W-1];
      z_o      = (q_val == '0);
      rem_we_o = ~ovf & ~same_i;
    end else begin
      quo_o    = {r_val[HW-1:0], q_val[HW-1:0]};
      n_o      = q_val[HW-1];
      z_o      = (q_val[HW-1:0] == '0);
      rem_we_o = 1'b0;
    end
    quo_we_o = ~ovf;
    v_o      = ovf;
    if (ovf) begin
      n_o = n_prev_i;
      z_o = 1'b0;
    end
  end
endmodule

// File: rtl/idiv_flags_unit.sv
module idiv_flags_unit
  import idiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   mode,
  input  logic [W-1:0] quo_src,
  input  logic [W-1:0] rem_src,
  input  logic [W-1:0] divisor,
  input  logic         same_dst,
  input  logic         n_prev,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo_res,
  output logic [W-1:0] rem_res,
  output logic         quo_we,
  output logic         rem_we,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v,
  output logic         flag_c,
  output logic         div_zero
);
  localparam int DW = 2 * W;

  // reset synchronizer: assert asynchronously, release on a clock edge
  logic [1:0] sync_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_n_i = sync_q[1];

  logic [DW-1:0] p_dvd_mag;
  logic [W-1:0]  p_dvs_mag;
  logic          p_dvd_neg, p_dvs_neg, p_dvs_zero;

  idiv_operand_prep #(.W(W)) u_prep (
    .mode_i     (mode),
    .lo_i       (quo_src),
    .hi_i       (rem_src),
    .dvs_i      (divisor),
    .dvd_mag_o  (p_dvd_mag),
    .dvs_mag_o  (p_dvs_mag),
    .dvd_neg_o  (p_dvd_neg),
    .dvs_neg_o  (p_dvs_neg),
    .dvs_zero_o (p_dvs_zero)
  );

  dstate_e    st_q, st_d;
  logic [1:0] mode_q;
  logic       qneg_q, rneg_q, same_q, nprev_q, trap_q;
  logic       accept, fin, c_last;

  assign accept = start & (st_q == ST_IDLE);
  assign fin    = (st_q == ST_FIN);

  logic [DW-1:0] c_q;
  logic [W-1:0]  c_r;

  idiv_restoring_core #(.W(W)) u_core (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .load_i (accept & ~p_dvs_zero),
    .long_i (mode[MODE_LONG_BIT]),
    .dvd_i  (p_dvd_mag),
    .dvs_i  (p_dvs_mag),
    .q_o    (c_q),
    .r_o    (c_r),
    .last_o (c_last)
  );

  logic [W-1:0] pk_quo, pk_rem;
  logic         pk_qwe, pk_rwe, pk_n, pk_z, pk_v;

  idiv_result_pack #(.W(W)) u_pack (
    .long_i   (mode_q[MODE_LONG_BIT]),
    .sgn_i    (mode_q[MODE_SIGN_BIT]),
    .q_neg_i  (qneg_q),
    .r_neg_i  (rneg_q),
    .q_mag_i  (c_q),
    .r_mag_i  (c_r),
    .same_i   (same_q),
    .n_prev_i (nprev_q),
    .quo_o    (pk_quo),
    .rem_o    (pk_rem),
    .quo_we_o (pk_qwe),
    .rem_we_o (pk_rwe),
    .n_o      (pk_n),
    .z_o      (pk_z),
    .v_o      (pk_v)
  );

  // sequencing
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = p_dvs_zero ? ST_FIN : ST_RUN;
      ST_RUN:  if (c_last) st_d = ST_FIN;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q    <= ST_IDLE;
      mode_q  <= '0;
      qneg_q  <= 1'b0;
      rneg_q  <= 1'b0;
      same_q  <= 1'b0;
      nprev_q <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        mode_q  <= mode;
        qneg_q  <= p_dvd_neg ^ p_dvs_neg;
        rneg_q  <= p_dvd_neg;
        same_q  <= same_dst;
        nprev_q <= n_prev;
        trap_q  <= p_dvs_zero;
      end
    end
  end

  // result registers
  logic         done_d, trap_d, qwe_d, rwe_d, n_d, z_d, v_d, data_en;

  always_comb begin
    done_d  = fin;
    trap_d  = fin & trap_q;
    qwe_d   = fin & ~trap_q & pk_qwe;
    rwe_d   = fin & ~trap_q & pk_rwe;
    n_d     = trap_q ? nprev_q : pk_n;
    z_d     = ~trap_q & pk_z;
    v_d     = ~trap_q & pk_v;
    data_en = fin & ~trap_q;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      done     <= 1'b0;
      div_zero <= 1'b0;
      quo_we   <= 1'b0;
      rem_we   <= 1'b0;
      flag_n   <= 1'b0;
      flag_z   <= 1'b0;
      flag_v   <= 1'b0;
      flag_c   <= 1'b0;
      quo_res  <= '0;
      rem_res  <= '0;
    end else begin
      done     <= done_d;
      div_zero <= trap_d;
      quo_we   <= qwe_d;
      rem_we   <= rwe_d;
      if (fin) begin
        flag_n <= n_d;
        flag_z <= z_d;
        flag_v <= v_d;
        flag_c <= 1'b0;
      end
      if (data_en) begin
        quo_res <= pk_quo;
        rem_res <= pk_rem;
      end
    end
  end

  assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/idiv_flags_chk.sv
module idiv_flags_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic quo_we,
  input logic rem_we,
  input logic flag_z,
  input logic flag_v,
  input logic flag_c,
  input logic div_zero
);
  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_busy_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_idle_at_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_we_with_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (quo_we || rem_we || div_zero) |-> done);
  assert_trap_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> (!quo_we && !rem_we && !flag_v && !flag_z));
  assert_ovf_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_v) |-> (!quo_we && !rem_we && !flag_z && !flag_c));
  assert_rem_needs_quo_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rem_we |-> quo_we);
endmodule

bind idiv_flags_unit idiv_flags_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n_i),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .quo_we   (quo_we),
  .rem_we   (rem_we),
  .flag_z   (flag_z),
  .flag_v   (flag_v),
  .flag_c   (flag_c),
  .div_zero (div_zero)
);

// File: tb/test_idiv_flags_unit.sv
module test_idiv_flags_unit;
  localparam int W = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n, start, same_dst, n_prev;
  logic [1:0]   mode;
  logic [W-1:0] quo_src, rem_src, divisor;
  logic         busy, done, quo_we, rem_we, flag_n, flag_z, flag_v, flag_c, div_zero;
  logic [W-1:0] quo_res, rem_res;

  int n_checks = 0;
  int n_err    = 0;
  bit finished = 0;

  idiv_flags_unit #(.W(W)) i_idiv_flags_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .quo_src(quo_src), .rem_src(rem_src), .divisor(divisor),
    .same_dst(same_dst), .n_prev(n_prev), .busy(busy), .done(done),
    .quo_res(quo_res), .rem_res(rem_res), .quo_we(quo_we), .rem_we(rem_we),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c),
    .div_zero(div_zero)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    check(1'b0, "R2", "watchdog expired", 80'd0, 80'd1);
    finish_run();
  end

  // one operation; entered and left at a falling edge
  task automatic run_op(input logic [1:0] md, input logic [31:0] lo, input logic [31:0] hi,
                        input logic [31:0] dv, input bit same, input bit np,
                        input bit gap, input bit poke);
    logic signed [71:0] a, b, q, r;
    bit trap, ovf;
    int lat, cyc;
    logic [79:0] act, exp;
    string tag;
    // R4: bit 0 signed, bit 1 long; word forms use divisor[15:0]
    case (md)
      2'b00: begin a = {40'd0, lo};            b = {56'd0, dv[15:0]}; end
      2'b01: begin a = {{40{lo[31]}}, lo};     b = {{56{dv[15]}}, dv[15:0]}; end
      2'b10: begin a = {8'd0, hi, lo};         b = {40'd0, dv}; end
      default: begin a = {{8{hi[31]}}, hi, lo}; b = {{40{dv[31]}}, dv}; end
    endcase
    trap = (b == 0);
    q = 0; r = 0; ovf = 0;
    if (!trap) begin
      q = a / b;
      r = a % b;
      case (md)
        2'b00: ovf = (q > 65535);
        2'b01: ovf = (q < -32768) || (q > 32767);
        2'b10: ovf = (q > 72'sd4294967295);
        default: ovf = (q < -72'sd2147483648) || (q > 72'sd2147483647);
      endcase
    end
    lat = trap ? 1 : (md[1] ? 65 : 33);

    mode = md; quo_src = lo; rem_src = hi; divisor = dv; same_dst = same; n_prev = np;
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    // R12: scramble every captured input once accepted
    mode = ~md; quo_src = ~lo; rem_src = lo ^ hi; divisor = dv + 32'd1;
    same_dst = ~same; n_prev = ~np;
    check(busy == 1'b1, "R1", "busy after accept", 80'(busy), 80'd1);
    cyc = 0;
    while (!done && cyc < 200) begin
      start = (poke && cyc == 3);  // R1: request while busy is ignored
      @(posedge clk); cyc++; @(negedge clk);
    end
    start = 1'b0;
    check(cyc == lat, "R2", "latency", 80'(cyc), 80'(lat));

    act = {quo_we, rem_we, div_zero, flag_n, flag_z, flag_v, flag_c, 1'b0, quo_res, rem_res};
    if (trap) begin
      exp = {1'b0, 1'b0, 1'b1, np, 1'b0, 1'b0, 1'b0, 1'b0, quo_res, rem_res};
      tag = "R3 R12";
    end else if (ovf) begin
      exp = {1'b0, 1'b0, 1'b0, np, 1'b0, 1'b1, 1'b0, 1'b0, quo_res, rem_res};
      tag = md[1] ? "R8 R9 R12" : "R7 R9 R12";
    end else if (!md[1]) begin
      exp = {1'b1, 1'b0, 1'b0, q[15], (q[15:0] == 16'd0), 1'b0, 1'b0, 1'b0,
             r[15:0], q[15:0], rem_res};
      tag = md[0] ? "R6 R10 R12" : "R5 R10 R12";
    end else begin
      exp = {1'b1, ~same, 1'b0, q[31], (q[31:0] == 32'd0), 1'b0, 1'b0, 1'b0,
             q[31:0], (same ? rem_res : r[31:0])};
      tag = same ? "R11 R10 R12" : (md[0] ? "R6 R11 R12" : "R4 R11 R12");
    end
    check(act == exp, tag, $sformatf("mode=%0d lo=%h hi=%h dv=%h", md, lo, hi, dv), act, exp);

    if (gap) begin
      @(posedge clk); @(negedge clk);
      check(!done && !busy, "R1", "idle after done", {78'd0, done, busy}, 80'd0);
    end
  endtask

  localparam logic [31:0] LO_SET [12] = '{32'h0, 32'h1, 32'h7, 32'h7FFF, 32'h8000, 32'hFFFF,
    32'h10000, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'hFFFF8000, 32'h12345678};
  localparam logic [31:0] HI_SET [5] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000};
  localparam logic [31:0] DV_SET [11] = '{32'h0, 32'h1, 32'h2, 32'h3, 32'hFFFF, 32'h8000,
    32'h7FFF, 32'hFFFFFFFF, 32'h80000000, 32'h10000, 32'h12345};

  initial begin
    int k;
    rst_n = 1'b0; start = 1'b0; mode = '0; quo_src = '0; rem_src = '0;
    divisor = '0; same_dst = 1'b0; n_prev = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !quo_we && !rem_we && !div_zero, "R1", "reset state",
          {75'd0, busy, done, quo_we, rem_we, div_zero}, 80'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    k = 0;
    // word forms: both signednesses over the corner grid
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 11; j++) begin
          k++;
          run_op(2'(m), LO_SET[i], 32'hA5A5A5A5, DV_SET[j], (k % 3) == 0, k[0],
                 k[1] | (k % 5 == 0), (k % 5) == 0);
        end
    // long forms: high half grid as well
    for (int m = 2; m < 4; m++)
      for (int h = 0; h < 5; h++)
        for (int i = 0; i < 12; i++)
          for (int j = 0; j < 11; j++) begin
            k++;
            run_op(2'(m), LO_SET[i], HI_SET[h], DV_SET[j], (k % 3) == 0, k[0],
                   k[1] | (k % 5 == 0), (k % 5) == 0);
          end
    // random mix with small high halves so that most results fit
    for (int t = 0; t < 300; t++) begin
      logic [31:0] lo, hi, dv;
      lo = $urandom;
      hi = (t % 4 == 0) ? $urandom : ($urandom & 32'h0000FFFF);
      dv = (t % 3 == 0) ? ($urandom & 32'h000000FF) : $urandom;
      run_op(2'($urandom), lo, hi, dv, t[0], t[1], t[2], (t % 7) == 0);
    end
    finish_run();
  end
endmodule